// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request port and an external asynchronous static RAM whose chip select is wired permanently active on the board. A requester presents an address, a direction and (for stores) a data word while `req_ready` is high. The block then takes sole control of the memory pins. It runs each access as a short, fixed sequence of clock cycles, timed so that the memory's access, pulse-width and hold limits are met at a 50 MHz system clock.

Loads are controlled entirely by the output-enable strobe. The block drives the address with output enable low for a programmable number of cycles. It captures the bus on the clock edge that ends the last of those cycles, and the word is presented together with a one-cycle valid pulse. Stores drive address and data with write enable low for a programmable number of cycles. Write enable is then raised while address and data are held for a programmable number of further cycles. The bidirectional data bus is released at every other time. All memory strobes come straight from flip-flops, so they cannot glitch.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, `sram_oe_n` and `sram_we_n` are 1, `req_ready` is 1 and `rd_valid` is 0.
- R2: A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both 1 (`req_write` 1 = store, 0 = load). From the next cycle `req_ready` stays 0 until the access sequence has ended. A `req_valid` presented while `req_ready` is 0 starts no access.
- R3: In the cycle after a load is accepted, `sram_addr` equals the request address and `sram_oe_n` is 0 for `RD_WAIT` cycles (default 1), with `sram_we_n` held at 1.
- R4: The load result is the bus value sampled at the clock edge that ends the last output-enable-low cycle. In the next cycle it appears on `rd_data` with `rd_valid` 1 for exactly one cycle, and `req_ready` is already 1 in that cycle.
- R5: In the cycle after a store is accepted, `sram_we_n` is 0 for `WE_CYCLES` cycles (default 1), while `sram_addr` shows the request address and `sram_dq` shows the store data.
- R6: After `sram_we_n` returns to 1, the address and store data stay driven unchanged for `HOLD_CYCLES` cycles (default 1). `req_ready` returns to 1 in the cycle after that.
- R7: `sram_oe_n` is 1 during every cycle of a store, including the hold cycles. `sram_oe_n` and `sram_we_n` are never both 0, and the block does not drive `sram_dq` while `sram_oe_n` is 0.
- R8: `rd_data` keeps its value until the next load completes, including across stores. A request presented in the cycle `req_ready` returns is accepted at once, so accesses can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Block idle, request can be accepted |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a new load result |
| rd_data | output | DW | Last load result |
| sram_addr | output | AW | Memory address bus |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_dq | inout | DW | Memory data bus |

## Verification
Assertions check several rules on every cycle. The output-enable and write-enable strobes are mutually exclusive, and the block never drives the bus while output enable is low. Write enable falling always coincides with the bus being driven, and write enable rising always leaves address and data unchanged. Acceptance always drops ready on the next cycle, valid pulses last one cycle, and the load result never changes outside a valid pulse. Other behaviour can only be shown by the directed scenarios against a small memory model. These cover the exact cycle in which each strobe moves, that data stored at an address comes back on a later load, that requests offered while busy are dropped, and that back-to-back accesses start without a gap.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_READ   = 2'd1,
        SEQ_WPULSE = 2'd2,
        SEQ_WHOLD  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int AW          = 18,
    parameter int DW          = 16,
    parameter int RD_WAIT     = 1,
    parameter int WE_CYCLES   = 1,
    parameter int HOLD_CYCLES = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic [AW-1:0] mem_addr,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          bus_drive,
    output logic [DW-1:0] bus_wdata,
    output logic          cap_en
);

    localparam int MAX_RW = (RD_WAIT > WE_CYCLES) ? RD_WAIT : WE_CYCLES;
    localparam int MAXC   = (MAX_RW > HOLD_CYCLES) ? MAX_RW : HOLD_CYCLES;
    localparam int CW     = $clog2(MAXC + 1);

    localparam logic [CW-1:0] RD_LOAD   = CW'(RD_WAIT - 1);
    localparam logic [CW-1:0] WE_LOAD   = CW'(WE_CYCLES - 1);
    localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          oe_n;
        logic          we_n;
        logic          drive;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        state: SEQ_IDLE,
        cnt:   '0,
        addr:  '0,
        wdata: '0,
        oe_n:  1'b1,
        we_n:  1'b1,
        drive: 1'b0
    };

    seq_t seq_d, seq_q;
    logic last_cycle;

    assign last_cycle = (seq_q.cnt == '0);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (req_valid) begin
                    seq_d.addr = req_addr;
                    if (req_write) begin
                        seq_d.state = SEQ_WPULSE;
                        seq_d.cnt   = WE_LOAD;
                        seq_d.wdata = req_wdata;
                        seq_d.we_n  = 1'b0;
                        seq_d.drive = 1'b1;
                    end else begin
                        seq_d.state = SEQ_READ;
                        seq_d.cnt   = RD_LOAD;
                        seq_d.oe_n  = 1'b0;
                    end
                end
            end
            SEQ_READ: begin
                if (last_cycle) begin
                    seq_d.state = SEQ_IDLE;
                    seq_d.oe_n  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SEQ_WPULSE: begin
                if (last_cycle) begin
                    seq_d.state = SEQ_WHOLD;
                    seq_d.cnt   = HOLD_LOAD;
                    seq_d.we_n  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SEQ_WHOLD: begin
                if (last_cycle) begin
                    seq_d.state = SEQ_IDLE;
                    seq_d.drive = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RESET;
        else        seq_q <= seq_d;
    end

    assign req_ready = (seq_q.state == SEQ_IDLE);
    assign mem_addr  = seq_q.addr;
    assign mem_oe_n  = seq_q.oe_n;
    assign mem_we_n  = seq_q.we_n;
    assign bus_drive = seq_q.drive;
    assign bus_wdata = seq_q.wdata;
    assign cap_en    = (seq_q.state == SEQ_READ) && last_cycle;

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5
    we_fall_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (bus_drive && mem_oe_n));

    // R6
    we_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (bus_drive && $stable(mem_addr) && $stable(bus_wdata)));

    // R7
    oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !bus_drive));

endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = cap_en;
        if (cap_en) cap_d.data = bus_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rd_data  = cap_q.data;
    assign rd_valid = cap_q.valid;

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
    parameter int AW          = 18,
    parameter int DW          = 16,
    parameter int RD_WAIT     = 1,
    parameter int WE_CYCLES   = 1,
    parameter int HOLD_CYCLES = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] sram_addr,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    inout  wire  [DW-1:0] sram_dq
);

    logic          bus_drive;
    logic [DW-1:0] bus_wdata;
    logic          cap_en;

    sram_ctrl_seq #(
        .AW(AW), .DW(DW), .RD_WAIT(RD_WAIT),
        .WE_CYCLES(WE_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .mem_addr  (sram_addr),
        .mem_oe_n  (sram_oe_n),
        .mem_we_n  (sram_we_n),
        .bus_drive (bus_drive),
        .bus_wdata (bus_wdata),
        .cap_en    (cap_en)
    );

    assign sram_dq = bus_drive ? bus_wdata : {DW{1'bz}};

    sram_ctrl_rdcap #(.DW(DW)) u_rdcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .bus_in   (sram_dq),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;

    localparam int AW = 18;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] sram_addr;
    logic          sram_oe_n;
    logic          sram_we_n;
    wire  [DW-1:0] sram_dq;

    int checks = 0;
    int errors = 0;
    logic model_armed = 1'b0;
    logic [DW-1:0] mem [16];

    always #5 clk = ~clk;

    sram_ctrl #(.AW(AW), .DW(DW)) i_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq(sram_dq)
    );

    // Memory model: drives the bus while output enable is low, stores on write-enable rise.
    assign sram_dq = (!sram_oe_n) ? mem[sram_addr[3:0]] : {DW{1'bz}};

    always @(posedge sram_we_n) begin
        if (model_armed) mem[sram_addr[3:0]] = sram_dq;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 oe_n in reset", 32'(sram_oe_n), 32'd1);
        chk("R1 we_n in reset", 32'(sram_we_n), 32'd1);
        rst_n = 1'b1;
        model_armed = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 rd_valid after reset", 32'(rd_valid), 32'd0);
        chk("R1 oe_n after reset", 32'(sram_oe_n), 32'd1);
        chk("R1 we_n after reset", 32'(sram_we_n), 32'd1);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        chk("R2 ready before store", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_wdata = ~d;
        chk("R5 we_n low", 32'(sram_we_n), 32'd0);
        chk("R5 addr", 32'(sram_addr), 32'(a));
        chk("R5 data on bus", 32'(sram_dq), 32'(d));
        chk("R7 oe_n high in pulse", 32'(sram_oe_n), 32'd1);
        chk("R2 ready low in pulse", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk("R6 we_n high in hold", 32'(sram_we_n), 32'd1);
        chk("R6 addr held", 32'(sram_addr), 32'(a));
        chk("R6 data held", 32'(sram_dq), 32'(d));
        chk("R7 oe_n high in hold", 32'(sram_oe_n), 32'd1);
        chk("R2 ready low in hold", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk("R6 ready after hold", 32'(req_ready), 32'd1);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 oe_n low", 32'(sram_oe_n), 32'd0);
        chk("R3 we_n high", 32'(sram_we_n), 32'd1);
        chk("R3 addr", 32'(sram_addr), 32'(a));
        chk("R2 ready low in load", 32'(req_ready), 32'd0);
        chk("R4 no valid yet", 32'(rd_valid), 32'd0);
        @(negedge clk);
        chk("R4 rd_valid", 32'(rd_valid), 32'd1);
        chk("R4 rd_data", 32'(rd_data), 32'(exp));
        chk("R4 ready with valid", 32'(req_ready), 32'd1);
        chk("R4 oe_n released", 32'(sram_oe_n), 32'd1);
        @(negedge clk);
        chk("R4 valid one cycle", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_busy_ignored;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'd5; req_wdata = 16'h5A5A;
        @(negedge clk);
        req_write = 1'b0; req_addr = 18'd9;
        @(negedge clk);
        chk("R2 busy request ignored oe_n", 32'(sram_oe_n), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 ready after store", 32'(req_ready), 32'd1);
        @(negedge clk);
        chk("R2 no load started oe_n", 32'(sram_oe_n), 32'd1);
        chk("R2 no store started we_n", 32'(sram_we_n), 32'd1);
        chk("R2 still ready", 32'(req_ready), 32'd1);
    endtask

    task automatic t_back_to_back;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'd3;
        @(negedge clk);
        req_addr = 18'd7;
        @(negedge clk);
        chk("R8 first valid", 32'(rd_valid), 32'd1);
        chk("R8 first data", 32'(rd_data), 32'h1234);
        chk("R8 ready for next", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 next load started at once", 32'(sram_oe_n), 32'd0);
        chk("R8 next addr", 32'(sram_addr), 32'd7);
        @(negedge clk);
        chk("R8 second valid", 32'(rd_valid), 32'd1);
        chk("R8 second data", 32'(rd_data), 32'hBEEF);
        @(negedge clk);
        t_write(18'd2, 16'h0F0F);
        chk("R8 rd_data kept across store", 32'(rd_data), 32'hBEEF);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'(i * 16'h0101);
        @(negedge clk);
        t_reset();
        t_write(18'd3, 16'h1234);
        t_write(18'd7, 16'hBEEF);
        t_read(18'd3, 16'h1234);
        t_read(18'd7, 16'hBEEF);
        t_read(18'd10, 16'h0A0A);
        t_busy_ignored();
        t_read(18'd5, 16'h5A5A);
        t_back_to_back();
        t_read(18'd2, 16'h0F0F);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule